// File: doc/BRIEF.md
# Indirect Register Access Data Register for a TAP

This block is a 20-bit test data register that sits behind one TAP instruction. Through it a debugger reads and writes a bank of internal registers without any direct path to them. The TAP controller and instruction decoder stay outside the block. They supply the capture, shift and update strobes and a select line. The register address comes from a separate data register as a plain input. On the other side is a register bus made of a valid/ready request channel and a one-cycle completion pulse that returns read data.

Each scan is built for short shifts. The operation code is held in the two topmost bits, so two shifted bits are enough to start a read. Write data is packed against bit 17, so a narrow register needs only its own width plus two bits. On capture, bit 0 reports the busy flag and the read result sits right-justified directly above it. One shifted bit therefore polls the flag, and a byte read needs nine shifts. A read or write issued while an access is still in flight goes into a one-entry holding slot. It is launched at the first capture that sees busy low.

Back-pressure rules: the request stays valid until the bus accepts it. Address, write flag and data stay stable while valid is high and ready is low. The bus must not raise `rsp_done` until it has accepted the request. The block accepts every completion and never holds one off. A completion seen while no access is waiting for one is ignored.

Top module: `tap_indirect_dr`

## Requirements
- R1: After synchronous reset, `busy` and `req_valid` are 0, the holding slot is empty, and the read result is zero. A capture right after reset therefore scans out twenty zero bits.
- R2: While `sel` and `shift` are high, each rising `tck` moves the register one place toward bit 0 and loads `tdi` into bit 19. `tdo` always shows bit 0. A shift of N bits places the new bits in positions 19 down to 20-N and leaves the bits below them unchanged.
- R3: On capture, bit 0 is loaded with the busy flag, bits 18:1 with the latest read result (result bit 0 at register bit 1), and bit 19 with 0.
- R4: On update with code 11 in bits 19:18, a write is issued to `reg_addr` sampled at that update, with `req_we`=1 and `req_wdata` equal to register bits 17:0. Data narrower than 18 bits is left-justified, so an 8-bit value shifted with its code in 10 bits arrives in `req_wdata[17:10]`.
- R5: On update with code 10 in bits 19:18, a read is issued with `req_we`=0. Shifting only the two code bits is enough.
- R6: On update with 0 in bit 19 (poll), no request is issued and neither the busy flag nor the holding slot changes.
- R7: `busy` rises on the edge that launches a request and stays high until the edge that samples `rsp_done`, after which it is 0.
- R8: A read completion stores `rsp_data` as the read result. A write completion leaves the read result unchanged.
- R9: A read or write updated while busy is high, or while the holding slot is full, is not issued at once. It is issued on the first capture edge at which busy is low, and that capture reports busy as 0.
- R10: The holding slot has one entry. A later read or write overwrites an earlier command still waiting there, and only the last one is issued.
- R11: `req_valid` stays high until `req_ready` is seen. While it waits, `req_addr`, `req_we` and `req_wdata` do not change.
- R12: With `sel` low, the capture, shift and update strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; also clocks the register bus |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Instruction decoder selects this register |
| capture | input | 1 | Capture-DR strobe |
| shift | input | 1 | Shift-DR strobe |
| update | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (register bit 0) |
| reg_addr | input | 8 | Target register address from the address data register |
| busy | output | 1 | Access in flight |
| req_valid | output | 1 | Bus request valid |
| req_ready | input | 1 | Bus accepts the request |
| req_we | output | 1 | 1 = write, 0 = read |
| req_addr | output | 8 | Request address |
| req_wdata | output | 18 | Request write data |
| rsp_done | input | 1 | One-cycle completion pulse |
| rsp_data | input | 18 | Read data valid with `rsp_done` |

## Verification
The bench targets truncated scans: a 10-bit write and a 2-bit read. If the design put the code at the bottom or right-justified the write data, the bus would see the wrong operation or the data in the wrong bits. It issues commands while an access is in flight and checks that nothing starts before a capture sees busy low. A design that launched straight from the holding slot, or dropped the held command, would show an early or missing request. It overwrites the held command and expects only the last one on the bus. It stalls `req_ready` and checks that the request holds steady. It also checks that a write completion does not clobber the read result, and that strobes are ignored while `sel` is low.

// File: rtl/tap_ind_pkg.sv
package tap_ind_pkg;
  localparam int DATA_W = 18;
  localparam int OP_W   = 2;
  localparam int SR_W   = DATA_W + OP_W;

  typedef enum logic [1:0] {
    OP_POLL0 = 2'b00,
    OP_POLL1 = 2'b01,
    OP_READ  = 2'b10,
    OP_WRITE = 2'b11
  } ind_op_e;
endpackage

// File: rtl/tap_ind_shreg.sv
module tap_ind_shreg #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_en,
  input  logic         shift_en,
  input  logic         tdi,
  input  logic [W-1:0] cap_word,
  output logic [W-1:0] sr,
  output logic         tdo
);
  always_ff @(posedge clk) begin
    if (rst)           sr <= '0;
    else if (cap_en)   sr <= cap_word;
    else if (shift_en) sr <= {tdi, sr[W-1:1]};
  end

  assign tdo = sr[0];

  // R2
  shift_top_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !cap_en) |=> (sr[W-1] == $past(tdi)));
endmodule

// File: rtl/tap_ind_ctrl.sv
module tap_ind_ctrl
  import tap_ind_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_fire,
  input  logic          upd_fire,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_data,
  input  logic [AW-1:0] addr_in,
  output logic          busy,
  output logic [DW-1:0] rd_result,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_we,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic          rsp_done,
  input  logic [DW-1:0] rsp_data
);
  logic          pend_v;
  logic          pend_we;
  logic [AW-1:0] pend_addr;
  logic [DW-1:0] pend_data;

  logic upd_cmd, launch_now, launch_pend, finish;
  assign upd_cmd     = upd_fire && (cmd_op == OP_READ || cmd_op == OP_WRITE);
  assign launch_now  = upd_cmd && !busy && !pend_v;
  assign launch_pend = cap_fire && !busy && pend_v;
  assign finish      = rsp_done && busy && !req_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      rd_result <= '0;
      req_valid <= 1'b0;
      req_we    <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      pend_v    <= 1'b0;
      pend_we   <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
    end else begin
      if (req_valid && req_ready) req_valid <= 1'b0;
      if (finish) begin
        busy <= 1'b0;
        if (!req_we) rd_result <= rsp_data;
      end
      if (launch_pend) begin
        busy      <= 1'b1;
        req_valid <= 1'b1;
        req_we    <= pend_we;
        req_addr  <= pend_addr;
        req_wdata <= pend_data;
        pend_v    <= 1'b0;
      end else if (launch_now) begin
        busy      <= 1'b1;
        req_valid <= 1'b1;
        req_we    <= (cmd_op == OP_WRITE);
        req_addr  <= addr_in;
        req_wdata <= cmd_data;
      end
      if (upd_cmd && (busy || pend_v)) begin
        pend_v    <= 1'b1;
        pend_we   <= (cmd_op == OP_WRITE);
        pend_addr <= addr_in;
        pend_data <= cmd_data;
      end
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                   && $stable(req_we) && $stable(req_wdata)));
  // R7
  busy_cover_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> busy);
  // R9
  launch_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_valid) |-> !$past(busy));
  // R6
  poll_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && !cmd_op[1] && !busy && !pend_v) |=> (!req_valid && !busy));
  // R7
  done_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && busy && !req_valid) |=> !busy);
endmodule

// File: rtl/tap_indirect_dr.sv
module tap_indirect_dr
  import tap_ind_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              tck,
  input  logic              rst,
  input  logic              sel,
  input  logic              capture,
  input  logic              shift,
  input  logic              update,
  input  logic              tdi,
  output logic              tdo,
  input  logic [AW-1:0]     reg_addr,
  output logic              busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_we,
  output logic [AW-1:0]     req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_done,
  input  logic [DATA_W-1:0] rsp_data
);
  logic              cap_fire, sh_fire, upd_fire;
  logic [SR_W-1:0]   sr;
  logic [SR_W-1:0]   cap_word;
  logic [DATA_W-1:0] rd_result;

  assign cap_fire = sel && capture;
  assign sh_fire  = sel && shift;
  assign upd_fire = sel && update;
  assign cap_word = {1'b0, rd_result, busy};

  tap_ind_shreg #(.W(SR_W)) u_shreg (
    .clk      (tck),
    .rst      (rst),
    .cap_en   (cap_fire),
    .shift_en (sh_fire),
    .tdi      (tdi),
    .cap_word (cap_word),
    .sr       (sr),
    .tdo      (tdo)
  );

  tap_ind_ctrl #(.AW(AW), .DW(DATA_W)) u_ctrl (
    .clk       (tck),
    .rst       (rst),
    .cap_fire  (cap_fire),
    .upd_fire  (upd_fire),
    .cmd_op    (sr[SR_W-1 -: OP_W]),
    .cmd_data  (sr[DATA_W-1:0]),
    .addr_in   (reg_addr),
    .busy      (busy),
    .rd_result (rd_result),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_done  (rsp_done),
    .rsp_data  (rsp_data)
  );

  // R3
  cap_busy_bit_chk: assert property (@(posedge tck) disable iff (rst)
    cap_fire |=> (tdo == $past(busy)));
endmodule

// File: tb/tap_indirect_dr_bench.sv
module tap_indirect_dr_bench;
  localparam int AW = 8;
  localparam int DW = 18;

  logic tck = 1'b0;
  always #4 tck = ~tck;

  logic rst = 1'b1, sel = 1'b0, capture = 1'b0, shift = 1'b0, update = 1'b0, tdi = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic req_ready = 1'b0, rsp_done = 1'b0;
  logic [DW-1:0] rsp_data = '0;
  logic tdo, busy, req_valid, req_we;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;

  tap_indirect_dr #(.AW(AW)) u_tap_indirect_dr (
    .tck(tck), .rst(rst), .sel(sel), .capture(capture), .shift(shift),
    .update(update), .tdi(tdi), .tdo(tdo), .reg_addr(reg_addr), .busy(busy),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
    .rsp_data(rsp_data)
  );

  int checks = 0, errors = 0;
  int ready_lag = 0, resp_lag = 2, req_count = 0, hold_cycles = 0;
  logic last_we;
  logic [AW-1:0] last_addr;
  logic [DW-1:0] last_wdata;

  function automatic logic [DW-1:0] model_rd(input logic [AW-1:0] a);
    return {a, 10'h2B5};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // register bus model
  task automatic responder();
    forever begin
      @(negedge tck);
      if (req_valid) begin
        logic [AW-1:0] a0;
        a0 = req_addr;
        hold_cycles = 1;
        for (int k = 0; k < ready_lag; k++) begin
          @(negedge tck);
          hold_cycles++;
          chk("R11 valid held", {31'd0, req_valid}, 32'd1);
          chk("R11 addr stable", {24'd0, req_addr}, {24'd0, a0});
        end
        req_ready  = 1'b1;
        last_we    = req_we;
        last_addr  = req_addr;
        last_wdata = req_wdata;
        req_count++;
        @(negedge tck);
        req_ready = 1'b0;
        repeat (resp_lag) @(negedge tck);
        rsp_done = 1'b1;
        rsp_data = model_rd(last_addr);
        @(negedge tck);
        rsp_done = 1'b0;
      end
    end
  endtask

  task automatic cap_cycle();
    capture = 1'b1; @(negedge tck); capture = 1'b0;
  endtask

  task automatic upd_cycle();
    update = 1'b1; @(negedge tck); update = 1'b0;
  endtask

  task automatic shift_bits(input int n, input logic [19:0] v, output logic [19:0] outv);
    outv = '0;
    for (int i = 0; i < n; i++) begin
      tdi = v[i];
      shift = 1'b1;
      outv[i] = tdo;
      @(negedge tck);
    end
    shift = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge tck);
  endtask

  task automatic t_reset();
    logic [19:0] o;
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 req_valid", {31'd0, req_valid}, 32'd0);
    cap_cycle();
    shift_bits(20, 20'h0, o);
    chk("R1 R3 capture after reset", {12'd0, o}, 32'd0);
  endtask

  task automatic t_full_write();
    logic [19:0] o;
    int n0;
    n0 = req_count;
    reg_addr = 8'h3C;
    shift_bits(20, {2'b11, 18'h2D1A7}, o);
    upd_cycle();
    chk("R7 busy rises", {31'd0, busy}, 32'd1);
    chk("R4 req_valid", {31'd0, req_valid}, 32'd1);
    @(negedge tck);
    chk("R4 write count", req_count, n0 + 1);
    chk("R4 we", {31'd0, last_we}, 32'd1);
    chk("R4 addr", {24'd0, last_addr}, 32'h3C);
    chk("R4 wdata", {14'd0, last_wdata}, 32'h2D1A7);
    cap_cycle();
    chk("R3 busy captured high", {31'd0, tdo}, 32'd1);
    wait_idle();
    chk("R7 busy falls", {31'd0, busy}, 32'd0);
  endtask

  task automatic t_short_write();
    logic [19:0] o;
    cap_cycle();
    reg_addr = 8'h05;
    shift_bits(10, {10'd0, 2'b11, 8'hA6}, o);
    upd_cycle();
    @(negedge tck);
    chk("R2 R4 short write we", {31'd0, last_we}, 32'd1);
    chk("R2 R4 short write data msb-aligned", {24'd0, last_wdata[17:10]}, 32'hA6);
    wait_idle();
  endtask

  task automatic t_short_read();
    logic [19:0] o;
    logic [DW-1:0] e;
    reg_addr = 8'h9E;
    e = model_rd(8'h9E);
    shift_bits(2, {18'd0, 2'b10}, o);
    upd_cycle();
    @(negedge tck);
    chk("R5 read we", {31'd0, last_we}, 32'd0);
    chk("R5 read addr", {24'd0, last_addr}, 32'h9E);
    wait_idle();
    cap_cycle();
    shift_bits(9, 20'h0, o);
    chk("R3 R8 byte read", {23'd0, o[8:0]}, {23'd0, e[7:0], 1'b0});
    cap_cycle();
    shift_bits(20, 20'h0, o);
    chk("R3 R8 full read", {12'd0, o}, {12'd0, 1'b0, e, 1'b0});
  endtask

  task automatic t_poll();
    logic [19:0] o;
    int n0;
    n0 = req_count;
    cap_cycle();
    shift_bits(1, 20'h0, o);
    chk("R6 poll busy bit", {31'd0, o[0]}, 32'd0);
    upd_cycle();
    chk("R6 poll no request", {31'd0, req_valid}, 32'd0);
    chk("R6 poll busy", {31'd0, busy}, 32'd0);
    repeat (3) @(negedge tck);
    chk("R6 poll count", req_count, n0);
  endtask

  task automatic t_write_keeps_result();
    logic [19:0] o;
    logic [DW-1:0] e;
    e = model_rd(8'h9E);
    reg_addr = 8'h71;
    shift_bits(20, {2'b11, 18'h00F0F}, o);
    upd_cycle();
    @(negedge tck);
    wait_idle();
    cap_cycle();
    shift_bits(19, 20'h0, o);
    chk("R8 write leaves result", {14'd0, o[18:1]}, {14'd0, e});
  endtask

  task automatic t_pending();
    logic [19:0] o;
    int n0;
    resp_lag = 20;
    reg_addr = 8'h11;
    shift_bits(20, {2'b11, 18'h12345}, o);
    upd_cycle();
    @(negedge tck);
    n0 = req_count;
    reg_addr = 8'h22;
    shift_bits(2, {18'd0, 2'b10}, o);
    upd_cycle();
    cap_cycle();
    chk("R9 busy captured", {31'd0, tdo}, 32'd1);
    @(negedge tck);
    chk("R9 no launch while busy", req_count, n0);
    wait_idle();
    repeat (2) @(negedge tck);
    chk("R9 no launch before capture", {31'd0, req_valid}, 32'd0);
    resp_lag = 2;
    cap_cycle();
    chk("R9 captured busy low", {31'd0, tdo}, 32'd0);
    chk("R9 launch on capture", {31'd0, req_valid}, 32'd1);
    chk("R9 launched read", {31'd0, req_we}, 32'd0);
    chk("R9 launched addr", {24'd0, req_addr}, 32'h22);
    @(negedge tck);
    wait_idle();
  endtask

  task automatic t_overwrite();
    logic [19:0] o;
    int n0;
    resp_lag = 15;
    reg_addr = 8'h40;
    shift_bits(20, {2'b11, 18'h0AAAA}, o);
    upd_cycle();
    @(negedge tck);
    n0 = req_count;
    reg_addr = 8'h41;
    shift_bits(2, {18'd0, 2'b10}, o);
    upd_cycle();
    reg_addr = 8'h42;
    shift_bits(20, {2'b11, 18'h15555}, o);
    upd_cycle();
    resp_lag = 2;
    wait_idle();
    cap_cycle();
    @(negedge tck);
    wait_idle();
    repeat (4) @(negedge tck);
    chk("R10 single launch", req_count, n0 + 1);
    chk("R10 last addr", {24'd0, last_addr}, 32'h42);
    chk("R10 last we", {31'd0, last_we}, 32'd1);
    chk("R10 last data", {14'd0, last_wdata}, 32'h15555);
  endtask

  task automatic t_backpressure();
    logic [19:0] o;
    ready_lag = 3;
    reg_addr = 8'h66;
    shift_bits(2, {18'd0, 2'b10}, o);
    upd_cycle();
    repeat (5) @(negedge tck);
    chk("R11 valid cycles", hold_cycles, 4);
    wait_idle();
    ready_lag = 0;
  endtask

  task automatic t_unselected();
    logic [19:0] o;
    int n0;
    n0 = req_count;
    cap_cycle();
    sel = 1'b0;
    shift_bits(20, 20'hFFFFF, o);
    chk("R12 shift ignored", {31'd0, tdo}, 32'd0);
    upd_cycle();
    cap_cycle();
    repeat (3) @(negedge tck);
    chk("R12 no request", req_count, n0);
    chk("R12 busy", {31'd0, busy}, 32'd0);
    sel = 1'b1;
  endtask

  bit finished = 0;

  initial begin
    fork responder(); join_none
    repeat (3) @(negedge tck);
    rst = 1'b0;
    sel = 1'b1;
    t_reset();
    t_full_write();
    t_short_write();
    t_short_read();
    t_poll();
    t_write_keeps_result();
    t_pending();
    t_overwrite();
    t_backpressure();
    t_unselected();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge tck);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule